// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Controller

This block sits between an on-chip request port and an external asynchronous static RAM that is 8 bits wide and has 2^18 locations. A client offers one read or write at a time over a valid/ready handshake. The controller then sequences the memory's pins: an address bus, a low-true and a high-true chip enable, low-true output-enable and write-enable strobes, and a data bus split into output value, output enable and input value. Read data comes back with a one-cycle response pulse.

Every strobe width and wait is a whole number of clock cycles, set by parameters. Each parameter is the nanosecond limit divided by the clock period and rounded up. The defaults suit an 8 ns clock and the fastest memory grade: a 7-cycle access window, a 6-cycle write pulse, a 4-cycle release after output-enable and a 7-cycle wake recovery.

A sleep request pulls the high-true enable low, which puts the memory into its low-power retention state. A wake request brings the memory back and holds off new requests until the recovery time has passed. Between requests the memory is deselected with the low-true enable high. The address register changes only at that time, while no strobe can act on the memory.

Top module: `asram_ctl`

## Requirements
- R1: After reset, req_ready is 1, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_ce is 1, and mem_dq_oe and rsp_valid are 0.
- R2: A write holds mem_we_n low for exactly WP_CYC consecutive cycles. It drives mem_dq_oe for one cycle before that window, through it, and for one cycle after it, with mem_ce_n low and mem_oe_n high. The location then holds the written byte.
- R3: mem_addr never changes between two consecutive cycles in which mem_ce_n is 0.
- R4: A read holds mem_oe_n low for ACC_CYC+1 cycles and samples mem_dq_i at the last of them. rsp_valid is high for exactly one cycle, ACC_CYC+2 rising edges after the accepting edge, and rsp_rdata then holds the stored byte.
- R5: mem_we_n is never low while mem_oe_n is low. mem_dq_oe is high whenever mem_we_n is low.
- R6: mem_dq_oe rises only after mem_oe_n has been high for at least HZ_CYC cycles. After a read, the controller waits HZ_CYC cycles with mem_oe_n high before it accepts another request.
- R7: Only one request is in flight. req_ready goes low on the accepting edge and stays low for ACC_CYC+HZ_CYC+2 cycles for a read and WP_CYC+2 cycles for a write.
- R8: In sleep, mem_ce is 0, mem_ce_n, mem_oe_n and mem_we_n are 1, and req_ready is 0. A request held at the port during sleep writes nothing.
- R9: After a wake request, req_ready stays low for REC_CYC cycles with mem_ce back at 1 and mem_ce_n at 1. After that the controller accepts requests again.
- R10: sleep_req is taken only in the idle state and wins over req_valid in the same cycle. req_ready is 0 while sleep_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write byte |
| rsp_valid | output | 1 | One-cycle pulse: read data available |
| rsp_rdata | output | DW | Read byte |
| sleep_req | input | 1 | Enter low-power retention (idle only) |
| wake_req | input | 1 | Leave retention |
| mem_addr | output | AW | Memory address pins |
| mem_ce_n | output | 1 | Low-true chip enable |
| mem_ce | output | 1 | High-true chip enable |
| mem_oe_n | output | 1 | Low-true output enable |
| mem_we_n | output | 1 | Low-true write enable |
| mem_dq_o | output | DW | Data driven to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | DW | Data from memory |

## Verification
The assertions assume that sleep_req and wake_req are not both high in the same cycle. They also assume that wake_req arrives only while the controller is asleep, and that mem_dq_i is settled by the end of the access window. The bench's memory model updates its read value on the falling edge. It raises wake only after it has checked the sleep state, and it never pulses sleep while a request is in flight. The request fields stay stable only for the cycle in which they are accepted, because the controller registers them.

// File: rtl/asram_ctl.sv
module asram_ctl #(
  parameter int AW      = 18,
  parameter int DW      = 8,
  parameter int ACC_CYC = 7,
  parameter int WP_CYC  = 6,
  parameter int HZ_CYC  = 4,
  parameter int REC_CYC = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic          sleep_req,
  input  logic          wake_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_ce,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int M1   = (ACC_CYC > WP_CYC) ? ACC_CYC : WP_CYC;
  localparam int M2   = (HZ_CYC > REC_CYC) ? HZ_CYC : REC_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    IDLE, SETUP, READ_WAIT, READ_CAPTURE, WRITE_PULSE, WRITE_HOLD, TURNAROUND, SLEEP
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          wr_q, rsp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      wr_q    <= 1'b0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      case (state)
        IDLE: begin
          if (sleep_req) state <= SLEEP;
          else if (req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            wr_q    <= req_write;
            state   <= SETUP;
          end
        end
        SETUP: begin
          if (wr_q) begin
            state <= WRITE_PULSE;
            cnt   <= CW'(WP_CYC - 1);
          end else begin
            state <= READ_WAIT;
            cnt   <= CW'(ACC_CYC - 1);
          end
        end
        READ_WAIT: begin
          if (cnt == '0) state <= READ_CAPTURE;
          else cnt <= cnt - 1'b1;
        end
        READ_CAPTURE: begin
          rdata_q <= mem_dq_i;
          rsp_q   <= 1'b1;
          state   <= TURNAROUND;
          cnt     <= CW'(HZ_CYC - 1);
        end
        WRITE_PULSE: begin
          if (cnt == '0) state <= WRITE_HOLD;
          else cnt <= cnt - 1'b1;
        end
        WRITE_HOLD: state <= IDLE;
        TURNAROUND: begin
          if (cnt == '0) state <= IDLE;
          else cnt <= cnt - 1'b1;
        end
        SLEEP: begin
          if (wake_req) begin
            state <= TURNAROUND;
            cnt   <= CW'(REC_CYC - 1);
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  logic sel;
  assign sel = (state == SETUP) || (state == READ_WAIT) || (state == READ_CAPTURE) ||
               (state == WRITE_PULSE) || (state == WRITE_HOLD);

  assign req_ready = (state == IDLE) && !sleep_req;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign mem_ce_n  = !sel;
  assign mem_ce    = (state != SLEEP);
  assign mem_oe_n  = !((state == READ_WAIT) || (state == READ_CAPTURE));
  assign mem_we_n  = (state != WRITE_PULSE);
  assign mem_dq_oe = wr_q && ((state == SETUP) || (state == WRITE_PULSE) || (state == WRITE_HOLD));

  logic [CW-1:0] we_len, oe_quiet;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_len   <= '0;
      oe_quiet <= CW'(HZ_CYC);
    end else begin
      we_len   <= mem_we_n ? '0 : we_len + 1'b1;
      if (!mem_oe_n) oe_quiet <= '0;
      else if (oe_quiet < CW'(HZ_CYC)) oe_quiet <= oe_quiet + 1'b1;
    end
  end

  a_r2_write_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> we_len == CW'(WP_CYC));
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  a_r4_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe));
  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> oe_quiet >= CW'(HZ_CYC));
  a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r8_sleep_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce |-> (mem_ce_n && mem_oe_n && mem_we_n && !req_ready));

endmodule

// File: tb/asram_ctl_tb_top.sv
`timescale 1ns/1ps
module asram_ctl_tb_top;
  localparam int AW = 18, DW = 8, ACC = 7, WP = 6, HZ = 4, REC = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, sleep_req = 1'b0, wake_req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_o;
  logic [DW-1:0] mem_dq_i = '0;
  logic [AW-1:0] mem_addr;

  int compared = 0, mismatched = 0;
  logic [DW-1:0] mem [int];

  always #4 clk = ~clk;

  asram_ctl #(.AW(AW), .DW(DW), .ACC_CYC(ACC), .WP_CYC(WP), .HZ_CYC(HZ), .REC_CYC(REC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sleep_req(sleep_req), .wake_req(wake_req),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  always @(posedge clk)
    if (!mem_ce_n && mem_ce && !mem_we_n && mem_dq_oe) mem[int'(mem_addr)] = mem_dq_o;

  always @(negedge clk)
    if (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n)
      mem_dq_i <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'hEE;
    else mem_dq_i <= 8'h00;

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic [AW-1:0] last_addr;
  logic last_sel = 1'b0;
  int mon_bad3 = 0, mon_bad5 = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n && last_sel && mem_addr != last_addr) mon_bad3++;
      if (!mem_we_n && (!mem_oe_n || !mem_dq_oe)) mon_bad5++;
    end
    last_addr = mem_addr;
    last_sel  = !mem_ce_n;
  end

  task automatic do_req(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int lat, output int pulses,
                        output int we_lo, output int oe_lo, output int busy, output int quiet);
    int n;
    rd = '0; lat = 0; pulses = 0; we_lo = 0; oe_lo = 0; busy = 0; quiet = 0;
    @(negedge clk);
    for (int i = 0; i < 100 && !req_ready; i++) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!req_ready && n < 200) begin
      busy++;
      if (!mem_we_n) we_lo++;
      if (!mem_oe_n) oe_lo++;
      else if (oe_lo > 0) quiet++;
      if (rsp_valid) begin pulses++; lat = n; rd = rsp_rdata; end
      @(negedge clk);
      n++;
    end
  endtask

  localparam logic [26:0] VEC [10] = '{
    {1'b1, 18'h00000, 8'hA5}, {1'b1, 18'h3FFFF, 8'h5A}, {1'b1, 18'h12345, 8'h3C},
    {1'b0, 18'h12345, 8'h3C}, {1'b0, 18'h00000, 8'hA5}, {1'b0, 18'h3FFFF, 8'h5A},
    {1'b1, 18'h12345, 8'hC3}, {1'b0, 18'h12345, 8'hC3}, {1'b1, 18'h00001, 8'hFF},
    {1'b0, 18'h00001, 8'hFF}
  };

  initial begin
    #160000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    int lat, pulses, we_lo, oe_lo, busy, quiet, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pins", {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_ce, mem_dq_oe, rsp_valid}, 7'b1111100);

    for (int i = 0; i < 10; i++) begin
      do_req(VEC[i][26], VEC[i][25:8], VEC[i][7:0], rd, lat, pulses, we_lo, oe_lo, busy, quiet);
      if (VEC[i][26]) begin
        check("R2 we_n low width", we_lo, WP);
        check("R2 stored byte", mem.exists(int'(VEC[i][25:8])) ? int'(mem[int'(VEC[i][25:8])]) : -1, int'(VEC[i][7:0]));
        check("R7 write busy", busy, WP + 2);
      end else begin
        check("R4 read data", rd, VEC[i][7:0]);
        check("R4 rsp latency", lat, ACC + 3);
        check("R4 rsp single pulse", pulses, 1);
        check("R4 oe_n low width", oe_lo, ACC + 1);
        check("R6 turnaround quiet", quiet, HZ);
        check("R7 read busy", busy, ACC + HZ + 2);
      end
    end
    check("R3 address stable while selected", mon_bad3, 0);
    check("R5 we/oe exclusion", mon_bad5, 0);

    // R10: sleep wins over a simultaneous write request
    @(negedge clk);
    sleep_req = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h12345; req_wdata = 8'h00;
    #1 check("R10 ready low with sleep_req", req_ready, 0);
    @(negedge clk);
    sleep_req = 1'b0;
    // R8 sleep pins, request held
    check("R8 sleep pins", {mem_ce, mem_ce_n, mem_oe_n, mem_we_n, req_ready}, 5'b01110);
    cnt = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (mem_ce || !mem_ce_n || req_ready) cnt++;
    end
    check("R8 stays asleep under requests", cnt, 0);
    req_valid = 1'b0;
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    cnt = 0;
    quiet = 0;
    while (!req_ready && cnt < 100) begin
      if (!mem_ce || !mem_ce_n) quiet++;
      cnt++;
      @(negedge clk);
    end
    check("R9 recovery length", cnt, REC);
    check("R9 pins during recovery", quiet, 0);
    do_req(1'b0, 18'h12345, 8'h00, rd, lat, pulses, we_lo, oe_lo, busy, quiet);
    check("R8 R10 request dropped in sleep", rd, 8'hC3);
    do_req(1'b1, 18'h2AAAA, 8'h69, rd, lat, pulses, we_lo, oe_lo, busy, quiet);
    do_req(1'b0, 18'h2AAAA, 8'h00, rd, lat, pulses, we_lo, oe_lo, busy, quiet);
    check("R9 works after wake", rd, 8'h69);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule